// File: doc/BRIEF.md
# Time Base, Decrementer and Event Counter

This block keeps the free-running time of a processor core and one selectable activity count. A 64-bit time base counts up and a 32-bit decrementer counts down. Both advance together on one clock out of every four, paced by an internal prescaler. A sticky expiry flag records that the decrementer has run through zero. Software can load either register at any time through a write strobe and data bus.

A 32-bit performance counter adds up one kind of event, chosen by a 6-bit select code. The events are:

- every clock;
- a 0-to-2 dispatch count;
- one of thirteen single-cycle event strobes;
- rising transitions of one of four time base bits, chosen by a 2-bit tap field.

Some codes are reserved, and those codes freeze the counter. The counter wraps modulo 2^32. A sticky flag records that its top bit has gone from 0 to 1 through counting. Software loads the counter through its own write port. The sources of the events and any interrupt delivery sit outside the block.

Top module: `clkbase_perfctr`

## Requirements
- R1: Reset state: `tb_value` = 0, `dec_value` = all ones, `pc_value` = 0, and both `dec_expired` and `pc_overflow` are 0.
- R2: Without writes, the time base rises by exactly N and the decrementer falls by exactly N over any 4N consecutive clocks. They advance on every fourth clock.
- R3: A write strobe on the time base, decrementer or counter takes priority over that cycle's step. The written value appears on the output one clock after the write edge.
- R4: When the decrementer steps from 0 to all ones, `dec_expired` is set and stays set. A decrementer write clears it.
- R5: Select code 0, and every code above 16, leave the counter unchanged whatever the event inputs do.
- R6: Select code 1 adds one on every clock.
- R7: Select code 4 adds `dispatch_cnt` each clock. A value of 3 is treated as 2.
- R8: Select code 2 counts the clocks where `evt_line[0]` is high. Code k, for k from 5 to 16, counts the clocks where `evt_line[k-4]` is high. All other lines have no effect on the count.
- R9: Select code 3 adds one for each 0-to-1 transition of one tap of `tb_value`, counted one clock after the bit rises. The tap is chosen by `tap_sel`: 0 picks bit 16, 1 picks bit 12, 2 picks bit 8, 3 picks bit 0 (LSB = 0). A software load that raises the bit also counts.
- R10: On the clock where `tap_sel` differs from its value in the previous clock, no transition is counted, even if the old tap was 0 and the new tap is 1.
- R11: The counter wraps modulo 2^32. Counting that takes bit 31 from 0 to 1 sets the sticky `pc_overflow`, and a counter write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_wr_en | input | 1 | Load strobe for the time base |
| tb_wr_data | input | 64 | Time base load value |
| dec_wr_en | input | 1 | Load strobe for the decrementer |
| dec_wr_data | input | 32 | Decrementer load value |
| pc_wr_en | input | 1 | Load strobe for the performance counter |
| pc_wr_data | input | 32 | Performance counter load value |
| evt_sel | input | 6 | Event select code |
| tap_sel | input | 2 | Time base tap used by code 3 |
| dispatch_cnt | input | 2 | Instructions dispatched this clock |
| evt_line | input | 13 | Single-cycle event strobes |
| tb_value | output | 64 | Time base |
| dec_value | output | 32 | Decrementer |
| dec_expired | output | 1 | Sticky decrementer expiry flag |
| pc_value | output | 32 | Performance counter |
| pc_overflow | output | 1 | Sticky counter overflow flag |

## Verification
The assertions assume that every input is a settled 0 or 1 at each clock edge, and that no write is in progress during reset. They also assume the dispatch count may take the value 3, which the block must clamp.

The stimulus changes inputs only on falling edges. It holds event inputs steady over counted windows, so each expected count is the window length times a fixed per-clock amount. For tap transitions, the time base is first loaded to a known value, and each window is made long enough to cover every tick and the one-clock detection lag that the result depends on.

// File: rtl/cb_pkg.sv
package cb_pkg;

    localparam int TB_W      = 64;
    localparam int DEC_W     = 32;
    localparam int PC_W      = 32;
    localparam int SEL_W     = 6;
    localparam int NUM_LINES = 13;
    localparam int TICK_DIV  = 4;
    localparam int NUM_TAPS  = 4;
    localparam int INC_W     = 2;

    // Select codes whose behaviour differs from a plain strobe
    localparam logic [SEL_W-1:0] EV_HOLD     = 6'd0;
    localparam logic [SEL_W-1:0] EV_CYCLE    = 6'd1;
    localparam logic [SEL_W-1:0] EV_LINE0    = 6'd2;
    localparam logic [SEL_W-1:0] EV_TAPEDGE  = 6'd3;
    localparam logic [SEL_W-1:0] EV_DISPATCH = 6'd4;
    localparam logic [SEL_W-1:0] EV_LINEBASE = 6'd4;  // code k -> line k-4
    localparam logic [SEL_W-1:0] EV_LAST     = 6'd16;

    // Tap positions counted from the most significant bit
    localparam int TAP_FROM_MSB [NUM_TAPS] = '{47, 51, 55, 63};

endpackage

// File: rtl/cb_prescale.sv
module cb_prescale #(
    parameter int DIV = cb_pkg::TICK_DIV
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    assign tick = (st_q.cnt == CW'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/cb_timebase.sv
module cb_timebase #(
    parameter int TB_W  = cb_pkg::TB_W,
    parameter int DEC_W = cb_pkg::DEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tb_wr_en,
    input  logic [TB_W-1:0]  tb_wr_data,
    input  logic             dec_wr_en,
    input  logic [DEC_W-1:0] dec_wr_data,
    output logic [TB_W-1:0]  tb_value,
    output logic [DEC_W-1:0] dec_value,
    output logic             dec_expired
);
    typedef struct packed {
        logic [TB_W-1:0]  tb;
        logic [DEC_W-1:0] dec;
        logic             expired;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // time base: load wins over tick
        if (tb_wr_en)  st_d.tb = tb_wr_data;
        else if (tick) st_d.tb = st_q.tb + 1'b1;
        // decrementer and its sticky expiry
        if (dec_wr_en) begin
            st_d.dec     = dec_wr_data;
            st_d.expired = 1'b0;
        end else if (tick) begin
            st_d.dec = st_q.dec - 1'b1;
            if (st_q.dec == '0) st_d.expired = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tb      <= '0;
            st_q.dec     <= '1;
            st_q.expired <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tb_value    = st_q.tb;
    assign dec_value   = st_q.dec;
    assign dec_expired = st_q.expired;

    AST_TB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tb_wr_en |=> (tb_value == $past(tb_wr_data))); // R3
    AST_TB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_wr_en && !tick) |=> $stable(tb_value)); // R2
    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dec_wr_en && dec_value == '0) |=> (dec_expired && dec_value == '1)); // R4
    AST_DEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wr_en |=> !dec_expired); // R4

endmodule

// File: rtl/cb_evsel.sv
module cb_evsel
    import cb_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   evt_sel,
    input  logic [1:0]         tap_sel,
    input  logic [1:0]         dispatch_cnt,
    input  logic [LINES-1:0]   evt_line,
    input  logic [NUM_TAPS-1:0] taps,
    output logic [INC_W-1:0]   inc_amt
);
    typedef struct packed {
        logic       prev_bit;
        logic [1:0] prev_sel;
    } state_t;

    state_t st_d, st_q;
    logic   cur_bit;
    logic   rise;
    logic   line_hit;

    assign cur_bit = taps[tap_sel];
    assign rise    = (tap_sel == st_q.prev_sel) && !st_q.prev_bit && cur_bit;

    always_comb begin
        st_d          = st_q;
        st_d.prev_bit = cur_bit;
        st_d.prev_sel = tap_sel;
    end

    // strobe lines: code 2 -> line 0, codes 5..16 -> lines 1..12
    always_comb begin
        line_hit = 1'b0;
        if (evt_sel == EV_LINE0) line_hit = evt_line[0];
        for (int k = 1; k < LINES; k++) begin
            if (evt_sel == SEL_W'(int'(EV_LINEBASE) + k)) line_hit = evt_line[k];
        end
    end

    always_comb begin
        case (evt_sel)
            EV_HOLD:     inc_amt = '0;
            EV_CYCLE:    inc_amt = INC_W'(1);
            EV_TAPEDGE:  inc_amt = INC_W'(rise);
            EV_DISPATCH: inc_amt = (dispatch_cnt == 2'd3) ? INC_W'(2) : INC_W'(dispatch_cnt);
            default:     inc_amt = INC_W'(line_hit);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_INC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc_amt <= INC_W'(2)); // R7
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sel == EV_HOLD || evt_sel > EV_LAST) |-> (inc_amt == '0)); // R5

endmodule

// File: rtl/cb_perfcount.sv
module cb_perfcount
    import cb_pkg::*;
#(
    parameter int W = PC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc_amt,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     value,
    output logic             overflow
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] sum;

    assign sum = st_q.cnt + W'(inc_amt);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt = wr_data;
            st_d.ovf = 1'b0;
        end else begin
            st_d.cnt = sum;
            if (!st_q.cnt[W-1] && sum[W-1]) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value    = st_q.cnt;
    assign overflow = st_q.ovf;

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value == $past(wr_data) && !overflow)); // R3
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (value - $past(value)) == W'($past(inc_amt))); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !wr_en) |=> overflow); // R11

endmodule

// File: rtl/clkbase_perfctr.sv
module clkbase_perfctr
    import cb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tb_wr_en,
    input  logic [TB_W-1:0]      tb_wr_data,
    input  logic                 dec_wr_en,
    input  logic [DEC_W-1:0]     dec_wr_data,
    input  logic                 pc_wr_en,
    input  logic [PC_W-1:0]      pc_wr_data,
    input  logic [SEL_W-1:0]     evt_sel,
    input  logic [1:0]           tap_sel,
    input  logic [1:0]           dispatch_cnt,
    input  logic [NUM_LINES-1:0] evt_line,
    output logic [TB_W-1:0]      tb_value,
    output logic [DEC_W-1:0]     dec_value,
    output logic                 dec_expired,
    output logic [PC_W-1:0]      pc_value,
    output logic                 pc_overflow
);
    logic                tick;
    logic [NUM_TAPS-1:0] taps;
    logic [INC_W-1:0]    inc_amt;

    cb_prescale #(.DIV(TICK_DIV)) u_prescale (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    cb_timebase #(.TB_W(TB_W), .DEC_W(DEC_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tb_wr_en   (tb_wr_en),
        .tb_wr_data (tb_wr_data),
        .dec_wr_en  (dec_wr_en),
        .dec_wr_data(dec_wr_data),
        .tb_value   (tb_value),
        .dec_value  (dec_value),
        .dec_expired(dec_expired)
    );

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign taps[g] = tb_value[TB_W - 1 - TAP_FROM_MSB[g]];
    end

    cb_evsel #(.LINES(NUM_LINES)) u_evsel (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_sel     (evt_sel),
        .tap_sel     (tap_sel),
        .dispatch_cnt(dispatch_cnt),
        .evt_line    (evt_line),
        .taps        (taps),
        .inc_amt     (inc_amt)
    );

    cb_perfcount #(.W(PC_W)) u_perfcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_amt (inc_amt),
        .wr_en   (pc_wr_en),
        .wr_data (pc_wr_data),
        .value   (pc_value),
        .overflow(pc_overflow)
    );

endmodule

// File: tb/clkbase_perfctr_test.sv
module clkbase_perfctr_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_wr_en = 1'b0;
    logic [63:0] tb_wr_data = '0;
    logic        dec_wr_en = 1'b0;
    logic [31:0] dec_wr_data = '0;
    logic        pc_wr_en = 1'b0;
    logic [31:0] pc_wr_data = '0;
    logic [5:0]  evt_sel = '0;
    logic [1:0]  tap_sel = '0;
    logic [1:0]  dispatch_cnt = '0;
    logic [12:0] evt_line = '0;
    logic [63:0] tb_value;
    logic [31:0] dec_value;
    logic        dec_expired;
    logic [31:0] pc_value;
    logic        pc_overflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    clkbase_perfctr uut (
        .clk(clk), .rst_n(rst_n),
        .tb_wr_en(tb_wr_en), .tb_wr_data(tb_wr_data),
        .dec_wr_en(dec_wr_en), .dec_wr_data(dec_wr_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
        .evt_sel(evt_sel), .tap_sel(tap_sel),
        .dispatch_cnt(dispatch_cnt), .evt_line(evt_line),
        .tb_value(tb_value), .dec_value(dec_value), .dec_expired(dec_expired),
        .pc_value(pc_value), .pc_overflow(pc_overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct packed {
        logic [5:0]  sel;
        logic [12:0] lines;
        logic [1:0]  disp;
        logic [7:0]  n;
        logic [31:0] expect_cnt;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{6'd0,  13'h1FFF, 2'd2, 8'd9,  32'd0,  8'd5},  // R5 hold code
        '{6'd17, 13'h1FFF, 2'd2, 8'd9,  32'd0,  8'd5},  // R5 reserved
        '{6'd63, 13'h1FFF, 2'd2, 8'd6,  32'd0,  8'd5},  // R5 reserved
        '{6'd1,  13'h0000, 2'd0, 8'd10, 32'd10, 8'd6},  // R6
        '{6'd4,  13'h0000, 2'd2, 8'd5,  32'd10, 8'd7},  // R7 two per clock
        '{6'd4,  13'h0000, 2'd1, 8'd6,  32'd6,  8'd7},  // R7 one per clock
        '{6'd4,  13'h0000, 2'd3, 8'd4,  32'd8,  8'd7},  // R7 clamp 3 -> 2
        '{6'd4,  13'h1FFF, 2'd0, 8'd4,  32'd0,  8'd7},  // R7 zero
        '{6'd2,  13'h0001, 2'd0, 8'd7,  32'd7,  8'd8},  // R8 line 0
        '{6'd2,  13'h1FFE, 2'd2, 8'd7,  32'd0,  8'd8},  // R8 other lines ignored
        '{6'd5,  13'h0002, 2'd0, 8'd6,  32'd6,  8'd8},  // R8 line 1
        '{6'd16, 13'h1000, 2'd0, 8'd3,  32'd3,  8'd8},  // R8 line 12
        '{6'd9,  13'h1FDF, 2'd0, 8'd5,  32'd0,  8'd8}   // R8 line 5 low
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        pc_wr_en = 1'b1; pc_wr_data = '0;
        evt_sel = v.sel; evt_line = v.lines; dispatch_cnt = v.disp;
        @(negedge clk);
        pc_wr_en = 1'b0;
        repeat (int'(v.n)) @(negedge clk);
        check($sformatf("R%0d vector sel=%0d", v.req, v.sel), 64'(pc_value), 64'(v.expect_cnt));
        evt_sel = '0; evt_line = '0; dispatch_cnt = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] t0;
        logic [31:0] d0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, sampled before the first active edge
        check("R1 tb reset", tb_value, 64'd0);
        check("R1 dec reset", 64'(dec_value), 64'hFFFF_FFFF);
        check("R1 pc reset", 64'(pc_value), 64'd0);
        check("R1 flags reset", 64'({dec_expired, pc_overflow}), 64'd0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R2 pacing: 40 clocks give 10 ticks
        @(negedge clk);
        t0 = tb_value; d0 = dec_value;
        repeat (40) @(negedge clk);
        check("R2 tb advance", tb_value, t0 + 64'd10);
        check("R2 dec advance", 64'(dec_value), 64'(d0 - 32'd10));

        // R3 write priority for all three registers
        @(negedge clk);
        tb_wr_en = 1'b1; tb_wr_data = 64'h1234_5678_9ABC_DEF0;
        dec_wr_en = 1'b1; dec_wr_data = 32'h0BAD_F00D;
        pc_wr_en = 1'b1; pc_wr_data = 32'h0000_7777; evt_sel = 6'd1;
        repeat (8) @(negedge clk);
        tb_wr_en = 1'b0; dec_wr_en = 1'b0; pc_wr_en = 1'b0; evt_sel = 6'd0;
        check("R3 tb write wins", tb_value, 64'h1234_5678_9ABC_DEF0);
        check("R3 dec write wins", 64'(dec_value), 64'h0BAD_F00D);
        check("R3 pc write wins", 64'(pc_value), 64'h7777);

        // R4 decrementer expiry
        dec_wr_en = 1'b1; dec_wr_data = 32'd2;
        @(negedge clk);
        dec_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 dec 2->1", 64'(dec_value), 64'd1);
        repeat (4) @(negedge clk);
        check("R4 no flag at zero", 64'({dec_expired, dec_value}), 64'd0);
        repeat (4) @(negedge clk);
        check("R4 wrap sets flag", 64'({dec_expired, dec_value}), 64'h1_FFFF_FFFF);
        repeat (8) @(negedge clk);
        check("R4 flag sticky", 64'(dec_expired), 64'd1);
        dec_wr_en = 1'b1; dec_wr_data = 32'd100;
        @(negedge clk);
        dec_wr_en = 1'b0;
        check("R4 write clears flag", 64'(dec_expired), 64'd0);

        // R9 tap 3 (bit 0): from 0, 64 clocks -> 8 rises
        tap_sel = 2'd3;
        @(negedge clk);
        tb_wr_en = 1'b1; tb_wr_data = '0; pc_wr_en = 1'b1; pc_wr_data = '0; evt_sel = 6'd3;
        @(negedge clk);
        tb_wr_en = 1'b0; pc_wr_en = 1'b0;
        repeat (64) @(negedge clk);
        check("R9 tap bit0 rises", 64'(pc_value), 64'd8);

        // R9 tap 2 (bit 8)
        evt_sel = 6'd0; tap_sel = 2'd2;
        @(negedge clk);
        tb_wr_en = 1'b1; tb_wr_data = 64'hFC; pc_wr_en = 1'b1; pc_wr_data = '0; evt_sel = 6'd3;
        @(negedge clk);
        tb_wr_en = 1'b0; pc_wr_en = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 tap bit8 rise", 64'(pc_value), 64'd1);

        // R9 tap 1 (bit 12)
        evt_sel = 6'd0; tap_sel = 2'd1;
        @(negedge clk);
        tb_wr_en = 1'b1; tb_wr_data = 64'hFFE; pc_wr_en = 1'b1; pc_wr_data = '0; evt_sel = 6'd3;
        @(negedge clk);
        tb_wr_en = 1'b0; pc_wr_en = 1'b0;
        repeat (12) @(negedge clk);
        check("R9 tap bit12 rise", 64'(pc_value), 64'd1);

        // R9 tap 0 (bit 16)
        evt_sel = 6'd0; tap_sel = 2'd0;
        @(negedge clk);
        tb_wr_en = 1'b1; tb_wr_data = 64'hFFFF; pc_wr_en = 1'b1; pc_wr_data = '0; evt_sel = 6'd3;
        @(negedge clk);
        tb_wr_en = 1'b0; pc_wr_en = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 tap bit16 rise", 64'(pc_value), 64'd1);

        // R10 changing the tap suppresses a false rise
        evt_sel = 6'd0; tap_sel = 2'd3;
        tb_wr_en = 1'b1; tb_wr_data = '0;
        @(negedge clk);
        tb_wr_data = 64'h100; pc_wr_en = 1'b1; pc_wr_data = '0; evt_sel = 6'd3;
        @(negedge clk);
        tb_wr_en = 1'b0; pc_wr_en = 1'b0; tap_sel = 2'd2;
        repeat (3) @(negedge clk);
        check("R10 no count on tap change", 64'(pc_value), 64'd0);
        evt_sel = 6'd0;

        // R11 overflow and wrap
        pc_wr_en = 1'b1; pc_wr_data = 32'h7FFF_FFFE; evt_sel = 6'd1;
        @(negedge clk);
        pc_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 overflow set", 64'({pc_overflow, pc_value}), 64'h1_8000_0000);
        pc_wr_en = 1'b1; pc_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        pc_wr_en = 1'b0;
        check("R3 pc write clears overflow", 64'({pc_overflow, pc_value}), 64'h0_FFFF_FFFF);
        @(negedge clk);
        check("R11 wrap to zero", 64'({pc_overflow, pc_value}), 64'd0);
        evt_sel = 6'd0;

        finish_run();
    end

endmodule